// File: doc/BRIEF.md
# Descriptor Ring Fetch Engine

This block follows one work queue that lives in memory as a ring of fixed 64-byte descriptor slots. Software advances a 64-bit producer index by writing it to the block. Each such write also acts as a doorbell. The block keeps its own 64-bit consumer index. Whenever the producer is ahead, it reads the next slot through a plain request/response memory port. Neither index ever wraps. Only the slot position wraps, and it is taken from the low bits of the index, so the ring size is a power of two.

A returned descriptor goes on to the execution logic over a valid/ready handshake only when its valid bit is set. A descriptor with the valid bit clear is discarded and its slot is read again. A polling mode lets the block read the slot at the consumer index with no producer write at all. Descriptors that software has already marked valid are then picked up on their own. A stop input halts new reads, and clearing it resumes from the same consumer index.

Top module: `desc_ring_fetch`

## Requirements
- R1: After reset the consumer index and the producer index are 0, no memory request or descriptor is presented, and the error flag is 0.
- R2: Every read request targets base + (index mod 2^sizeLog2) × 64, where index is the consumer index at the time of the request. The address stays stable while the request waits for ready.
- R3: A producer write whose value is not below the consumer index is stored as the new producer index. It starts fetching whenever it leaves the producer index above the consumer index.
- R4: With polling off and the producer index not above the consumer index, no read request is issued.
- R5: With polling on, the slot at the consumer index is read even when the producer index equals the consumer index. A valid descriptor found there is delivered, and the consumer index advances.
- R6: A returned descriptor whose bit 0 (valid) is 0 is never presented downstream. The consumer index stays unchanged, and the same slot is read again.
- R7: Descriptors are delivered strictly in consumer-index order. Each carries its index, and the consumer index increases by exactly one per delivered descriptor.
- R8: While stop is high and no read is outstanding, no new request is issued and the stopped flag is high. After stop is released, fetching resumes at the saved consumer index.
- R9: A producer write below the consumer index is discarded, leaving the producer index unchanged. It sets the error flag, which then stays set until reset.
- R10: A presented descriptor and its index stay unchanged until ready is seen. No further slot is read while one is held.
- R11: Indexes keep counting past the ring size: after passing slot 2^sizeLog2−1 the address returns to slot 0 while the index reads 2^sizeLog2 and above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfgBase | input | ADDR_W | Byte address of ring slot 0 |
| cfgSizeLog2 | input | LOG_W | log2 of the number of slots (clamped to MAX_LOG2) |
| pollEn | input | 1 | Read the consumer slot even when no work is announced |
| stopReq | input | 1 | Halt new reads; low resumes |
| prodWrValid | input | 1 | Producer index write / doorbell strobe |
| prodWrIndex | input | 64 | New producer index |
| memReqValid | output | 1 | Read request |
| memReqReady | input | 1 | Memory accepts the request |
| memReqAddr | output | ADDR_W | Read byte address |
| memRspValid | input | 1 | Read data returned |
| memRspData | input | DESC_W | Descriptor read from memory, bit 0 is valid |
| descValid | output | 1 | Descriptor presented downstream |
| descReady | input | 1 | Downstream accepts the descriptor |
| descData | output | DESC_W | Presented descriptor |
| descIndex | output | 64 | Ring index of the presented descriptor |
| consIndex | output | 64 | Current consumer index |
| prodIndex | output | 64 | Current producer index |
| idxError | output | 1 | Sticky flag: a producer write fell below the consumer index |
| fetchStopped | output | 1 | Stop is in force and no read is outstanding |

## Verification
The bench uses a 32-bit address, a 64-bit descriptor and a ring limit of 16 slots, and runs the ring at eight slots. This way a few dozen descriptors already carry the consumer index past the slot count, and address wrap can be observed beside an index that keeps growing. The memory model throttles request ready and answers after a short delay, while downstream ready drops every fifth cycle. This puts held descriptors and waiting requests on the same path as ordinary traffic. Stop, polling, invalid slots and a backward producer write are each staged at a known index, so the expected address and index are fixed in advance.

// File: rtl/ringfetch_pkg.sv
package ringfetch_pkg;

  // Fetch sequencer states
  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_REQ  = 2'd1,
    FS_WAIT = 2'd2
  } fetchState_t;

  // Strobes from the sequencer to the index/descriptor datapath
  typedef struct packed {
    logic latchAddr;    // freeze slot address for the request being opened
    logic captureDesc;  // a returned descriptor was valid: hold it, advance index
  } fetchStrobe_t;

endpackage

// File: rtl/ringfetch_ctrl.sv
module ringfetch_ctrl
  import ringfetch_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         stopReq,
  input  logic         pollEn,
  input  logic         workPending,
  input  logic         outFull,
  input  logic         memReqReady,
  input  logic         memRspValid,
  input  logic         rspValidBit,
  output logic         memReqValid,
  output logic         fetchStopped,
  output fetchStrobe_t strobe
);

  fetchState_t state, nextState;

  always_comb begin
    nextState = state;
    strobe    = '0;
    case (state)
      FS_IDLE: begin
        if (!stopReq && !outFull && (workPending || pollEn)) begin
          nextState        = FS_REQ;
          strobe.latchAddr = 1'b1;
        end
      end
      FS_REQ: begin
        if (memReqReady) nextState = FS_WAIT;
      end
      FS_WAIT: begin
        if (memRspValid) begin
          strobe.captureDesc = rspValidBit;
          nextState          = FS_IDLE;
        end
      end
      default: nextState = FS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= FS_IDLE;
    else        state <= nextState;
  end

  assign memReqValid  = (state == FS_REQ);
  assign fetchStopped = stopReq && (state == FS_IDLE);

  AST_STOP_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    fetchStopped |=> !memReqValid); // R8

  AST_EMPTY_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (state == FS_IDLE && !workPending && !pollEn) |=> !memReqValid); // R4

  AST_HELD_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (state == FS_IDLE && outFull) |=> !memReqValid); // R10

endmodule

// File: rtl/ringfetch_dp.sv
module ringfetch_dp
  import ringfetch_pkg::*;
#(
  parameter int ADDR_W     = 48,
  parameter int DESC_W     = 512,
  parameter int IDX_W      = 64,
  parameter int MAX_LOG2   = 16,
  parameter int SLOT_SHIFT = 6,
  parameter int VALID_BIT  = 0,
  parameter int LOG_W      = $clog2(MAX_LOG2 + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cfgBase,
  input  logic [LOG_W-1:0]  cfgSizeLog2,
  input  logic              prodWrValid,
  input  logic [IDX_W-1:0]  prodWrIndex,
  input  logic [DESC_W-1:0] memRspData,
  input  logic              descReady,
  input  fetchStrobe_t      strobe,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic              workPending,
  output logic              outFull,
  output logic              rspValidBit,
  output logic              descValid,
  output logic [DESC_W-1:0] descData,
  output logic [IDX_W-1:0]  descIndex,
  output logic [IDX_W-1:0]  consIndex,
  output logic [IDX_W-1:0]  prodIndex,
  output logic              idxError
);

  logic [IDX_W-1:0]  rdIdxQ, wrIdxQ, descIdxQ;
  logic [DESC_W-1:0] descQ;
  logic [ADDR_W-1:0] addrQ;
  logic              fullQ, errQ;

  // Slot arithmetic: ring size is a power of two, slot = low bits of index
  logic [LOG_W-1:0]  effLog2;
  logic [IDX_W-1:0]  slotMask, slotOffset;
  logic [ADDR_W-1:0] nextAddr;

  always_comb begin
    effLog2    = (int'(cfgSizeLog2) > MAX_LOG2) ? LOG_W'(MAX_LOG2) : cfgSizeLog2;
    slotMask   = ~({IDX_W{1'b1}} << effLog2);
    slotOffset = (rdIdxQ & slotMask) << SLOT_SHIFT;
    nextAddr   = cfgBase + slotOffset[ADDR_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdIdxQ   <= '0;
      wrIdxQ   <= '0;
      descIdxQ <= '0;
      descQ    <= '0;
      addrQ    <= '0;
      fullQ    <= 1'b0;
      errQ     <= 1'b0;
    end else begin
      if (prodWrValid) begin
        if (prodWrIndex < rdIdxQ) errQ   <= 1'b1;
        else                      wrIdxQ <= prodWrIndex;
      end
      if (strobe.latchAddr) addrQ <= nextAddr;
      if (strobe.captureDesc) begin
        descQ    <= memRspData;
        descIdxQ <= rdIdxQ;
        rdIdxQ   <= rdIdxQ + 1'b1;
        fullQ    <= 1'b1;
      end else if (fullQ && descReady) begin
        fullQ <= 1'b0;
      end
    end
  end

  assign memReqAddr  = addrQ;
  assign workPending = (wrIdxQ > rdIdxQ);
  assign outFull     = fullQ;
  assign rspValidBit = memRspData[VALID_BIT];
  assign descValid   = fullQ;
  assign descData    = descQ;
  assign descIndex   = descIdxQ;
  assign consIndex   = rdIdxQ;
  assign prodIndex   = wrIdxQ;
  assign idxError    = errQ;

  AST_RD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rdIdxQ == $past(rdIdxQ)) || (rdIdxQ == $past(rdIdxQ) + 1'b1)); // R7

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (fullQ && !descReady) |=> (fullQ && $stable(descQ) && $stable(descIdxQ))); // R10

  AST_VALID_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    fullQ |-> descQ[VALID_BIT]); // R6

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    errQ |=> errQ); // R9

  AST_LOW_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (prodWrValid && prodWrIndex < rdIdxQ) |=> (errQ && $stable(wrIdxQ))); // R9

endmodule

// File: rtl/desc_ring_fetch.sv
module desc_ring_fetch
  import ringfetch_pkg::*;
#(
  parameter int ADDR_W     = 48,
  parameter int DESC_W     = 512,
  parameter int MAX_LOG2   = 16,
  parameter int VALID_BIT  = 0,
  parameter int IDX_W      = 64,
  parameter int SLOT_SHIFT = 6,
  parameter int LOG_W      = $clog2(MAX_LOG2 + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cfgBase,
  input  logic [LOG_W-1:0]  cfgSizeLog2,
  input  logic              pollEn,
  input  logic              stopReq,
  input  logic              prodWrValid,
  input  logic [IDX_W-1:0]  prodWrIndex,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic [ADDR_W-1:0] memReqAddr,
  input  logic              memRspValid,
  input  logic [DESC_W-1:0] memRspData,
  output logic              descValid,
  input  logic              descReady,
  output logic [DESC_W-1:0] descData,
  output logic [IDX_W-1:0]  descIndex,
  output logic [IDX_W-1:0]  consIndex,
  output logic [IDX_W-1:0]  prodIndex,
  output logic              idxError,
  output logic              fetchStopped
);

  fetchStrobe_t strobe;
  logic workPending, outFull, rspValidBit;

  ringfetch_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .stopReq      (stopReq),
    .pollEn       (pollEn),
    .workPending  (workPending),
    .outFull      (outFull),
    .memReqReady  (memReqReady),
    .memRspValid  (memRspValid),
    .rspValidBit  (rspValidBit),
    .memReqValid  (memReqValid),
    .fetchStopped (fetchStopped),
    .strobe       (strobe)
  );

  ringfetch_dp #(
    .ADDR_W     (ADDR_W),
    .DESC_W     (DESC_W),
    .IDX_W      (IDX_W),
    .MAX_LOG2   (MAX_LOG2),
    .SLOT_SHIFT (SLOT_SHIFT),
    .VALID_BIT  (VALID_BIT),
    .LOG_W      (LOG_W)
  ) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfgBase     (cfgBase),
    .cfgSizeLog2 (cfgSizeLog2),
    .prodWrValid (prodWrValid),
    .prodWrIndex (prodWrIndex),
    .memRspData  (memRspData),
    .descReady   (descReady),
    .strobe      (strobe),
    .memReqAddr  (memReqAddr),
    .workPending (workPending),
    .outFull     (outFull),
    .rspValidBit (rspValidBit),
    .descValid   (descValid),
    .descData    (descData),
    .descIndex   (descIndex),
    .consIndex   (consIndex),
    .prodIndex   (prodIndex),
    .idxError    (idxError)
  );

  AST_REQ_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (memReqValid && !memReqReady) |=> (memReqValid && $stable(memReqAddr))); // R2

endmodule

// File: tb/desc_ring_fetch_bench.sv
`timescale 1ns/100ps
module desc_ring_fetch_bench;

  localparam int ADDR_W   = 32;
  localparam int DESC_W   = 64;
  localparam int MAX_LOG2 = 4;
  localparam int LOG_W    = $clog2(MAX_LOG2 + 1);
  localparam int RING_LOG2 = 3;
  localparam logic [ADDR_W-1:0] BASE = 32'h0001_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [ADDR_W-1:0] cfgBase = BASE;
  logic [LOG_W-1:0]  cfgSizeLog2 = LOG_W'(RING_LOG2);
  logic pollEn = 1'b0, stopReq = 1'b0, prodWrValid = 1'b0;
  logic [63:0] prodWrIndex = '0;
  logic memReqValid, memReqReady, memRspValid = 1'b0;
  logic [ADDR_W-1:0] memReqAddr;
  logic [DESC_W-1:0] memRspData = '0;
  logic descValid, descReady, idxError, fetchStopped;
  logic [DESC_W-1:0] descData;
  logic [63:0] descIndex, consIndex, prodIndex;

  desc_ring_fetch #(.ADDR_W(ADDR_W), .DESC_W(DESC_W), .MAX_LOG2(MAX_LOG2)) u_desc_ring_fetch (
    .clk(clk), .rst_n(rst_n), .cfgBase(cfgBase), .cfgSizeLog2(cfgSizeLog2),
    .pollEn(pollEn), .stopReq(stopReq), .prodWrValid(prodWrValid), .prodWrIndex(prodWrIndex),
    .memReqValid(memReqValid), .memReqReady(memReqReady), .memReqAddr(memReqAddr),
    .memRspValid(memRspValid), .memRspData(memRspData),
    .descValid(descValid), .descReady(descReady), .descData(descData), .descIndex(descIndex),
    .consIndex(consIndex), .prodIndex(prodIndex), .idxError(idxError), .fetchStopped(fetchStopped));

  int checks = 0, errors = 0, reqCount = 0, cyc = 0;
  longint modelRd = 0;
  logic [DESC_W-1:0] mem [0:15];
  longint expQ[$];
  bit busy = 0;
  int lat = 0;
  logic [ADDR_W-1:0] pendAddr = '0;
  bit holdSeen = 0;
  logic [DESC_W-1:0] holdData = '0;
  logic [63:0] holdIdx = '0;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [DESC_W-1:0] mkDesc(input longint idx);
    return {32'hA5A5_0000 + 32'(idx), 31'(idx * 3), 1'b1};
  endfunction

  function automatic int slotOf(input logic [ADDR_W-1:0] a);
    return int'(((a - BASE) >> 6) & 32'hF);
  endfunction

  always @(posedge clk) cyc <= cyc + 1;
  assign memReqReady = !busy && (cyc % 3 != 1);
  assign descReady   = (cyc % 5 != 2);

  // Memory model: one read in flight, answers two cycles after accept
  always @(posedge clk) begin
    memRspValid <= 1'b0;
    if (!rst_n) begin
      busy <= 0;
    end else if (busy) begin
      if (lat == 0) begin
        memRspValid <= 1'b1;
        memRspData  <= mem[slotOf(pendAddr)];
        busy <= 0;
      end else lat <= lat - 1;
    end else if (memReqValid && memReqReady) begin
      logic [ADDR_W-1:0] expAddr;
      expAddr = BASE + ADDR_W'((modelRd & ((64'd1 << RING_LOG2) - 1)) << 6);
      check(memReqAddr == expAddr, "R2 request address", 64'(memReqAddr), 64'(expAddr));
      pendAddr <= memReqAddr;
      busy <= 1;
      lat <= 1;
      reqCount++;
    end
  end

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && descValid) begin
      check(descData[0] == 1'b1, "R6 presented descriptor valid bit", 64'(descData[0]), 64'd1);
      if (holdSeen)
        check(descData == holdData && descIndex == holdIdx, "R10 held descriptor stable",
              descIndex, holdIdx);
      if (descReady) begin
        holdSeen = 0;
        if (expQ.size() == 0) begin
          check(1'b0, "R7 unexpected descriptor", descIndex, 64'hFFFF_FFFF_FFFF_FFFF);
        end else begin
          longint e;
          e = expQ.pop_front();
          check(descIndex == 64'(e), "R7 delivery index order", descIndex, 64'(e));
          check(descData == mkDesc(e), "R7 delivered data", descData, mkDesc(e));
          modelRd++;
        end
      end else begin
        holdSeen = 1;
        holdData = descData;
        holdIdx  = descIndex;
      end
    end
  end

  task automatic post(input longint idx);
    mem[int'(idx & 7)] = mkDesc(idx);
    expQ.push_back(idx);
  endtask

  task automatic prodWrite(input longint v);
    @(posedge clk); #1;
    prodWrValid = 1'b1;
    prodWrIndex = 64'(v);
    @(posedge clk); #1;
    prodWrValid = 1'b0;
  endtask

  task automatic drain(input string tag);
    int n;
    n = 0;
    while (expQ.size() != 0 && n < 3000) begin
      @(negedge clk);
      n++;
    end
    check(expQ.size() == 0, tag, 64'(expQ.size()), 64'd0);
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int rc;
    for (int i = 0; i < 16; i++) mem[i] = '0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    @(negedge clk);
    check(consIndex == 0 && prodIndex == 0, "R1 indexes after reset", consIndex, 64'd0);
    check(!descValid && !memReqValid && !idxError, "R1 outputs idle after reset",
          {61'd0, descValid, memReqValid, idxError}, 64'd0);

    // R4 empty ring, polling off: no reads
    rc = reqCount;
    repeat (20) @(negedge clk);
    check(reqCount == rc, "R4 no request while empty", 64'(reqCount - rc), 64'd0);

    // R3 doorbell write starts fetching, five descriptors
    for (int i = 0; i < 5; i++) post(i);
    prodWrite(5);
    @(negedge clk);
    check(prodIndex == 5, "R3 producer index stored", prodIndex, 64'd5);
    drain("R3 doorbell descriptors delivered");
    check(consIndex == 5, "R3 consumer index after batch", consIndex, 64'd5);

    // R11 wrap: indexes 5..10 cross the eight-slot boundary
    for (int i = 5; i < 11; i++) post(i);
    prodWrite(11);
    drain("R11 wrapped descriptors delivered");
    check(consIndex == 11, "R11 index continues past ring size", consIndex, 64'd11);

    // R6 invalid slot for index 11 is not delivered, slot is read again
    mem[3] = mkDesc(11) & ~64'd1;
    rc = reqCount;
    prodWrite(12);
    repeat (40) @(negedge clk);
    check(consIndex == 11, "R6 index held on invalid slot", consIndex, 64'd11);
    check(reqCount - rc >= 2, "R6 invalid slot re-read", 64'(reqCount - rc), 64'd2);
    check(!descValid, "R6 invalid descriptor not presented", 64'(descValid), 64'd0);
    post(11);
    drain("R6 descriptor delivered once valid");

    // R5 polling with producer == consumer
    for (int i = 0; i < 8; i++) mem[i] = '0;
    post(12);
    @(posedge clk); #1 pollEn = 1'b1;
    drain("R5 polled descriptor delivered");
    check(consIndex == 13 && prodIndex == 12, "R5 consumer advanced by polling", consIndex, 64'd13);
    @(posedge clk); #1 pollEn = 1'b0;
    repeat (10) @(negedge clk);
    rc = reqCount;
    repeat (20) @(negedge clk);
    check(reqCount == rc, "R4 polling off stops reads", 64'(reqCount - rc), 64'd0);

    // R9 producer write below consumer index
    prodWrite(5);
    @(negedge clk);
    check(idxError == 1'b1, "R9 error flag raised", 64'(idxError), 64'd1);
    check(prodIndex == 12, "R9 low write ignored", prodIndex, 64'd12);
    prodWrite(13);
    @(negedge clk);
    check(prodIndex == 13 && idxError, "R9 error sticky after good write", prodIndex, 64'd13);

    // R8 stop and resume
    @(posedge clk); #1 stopReq = 1'b1;
    repeat (3) @(negedge clk);
    post(13);
    post(14);
    rc = reqCount;
    prodWrite(15);
    repeat (20) @(negedge clk);
    check(reqCount == rc, "R8 no request while stopped", 64'(reqCount - rc), 64'd0);
    check(fetchStopped && consIndex == 13, "R8 stopped flag and saved index", consIndex, 64'd13);
    @(posedge clk); #1 stopReq = 1'b0;
    drain("R8 resumed descriptors delivered");
    check(consIndex == 15, "R8 consumer index after resume", consIndex, 64'd15);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule